// File: doc/BRIEF.md
# Band-Window Sample Offset Stage

This stage corrects a stream of 8-bit reconstructed samples by adding a small signed offset, chosen by the intensity band that each sample falls in. The 0 to 255 range is cut into 32 equal bands, each eight codes wide. A region's configuration names a starting band and four offsets. Those offsets apply to the starting band and the three bands after it. Every other sample goes through unchanged.

Software or an upstream parser loads the configuration with a single strobe in a gap between regions. Samples then enter with a valid flag. Each corrected sample leaves one clock later, clipped to the legal sample range. The window of four bands wraps around the top of the band range, so a start near band 31 continues at band 0.

Top module: `sao_band_apply`

## Requirements
- R1: After reset, out_valid is 0, out_pix is 0, the stored start band is 0 and all four stored offsets are 0.
- R2: A sample's band is in_pix >> 3. Its slot is (band − start) mod 32. When the slot is below 4, the offset held in cfg_ofs bits [4·slot+3 : 4·slot] is added to the sample.
- R3: The window wraps modulo 32. For example, start 30 covers bands 30, 31, 0 and 1, using slots 0 to 3 in that order.
- R4: Each offset is 4-bit two's complement, from −8 to +7. A negative offset lowers the sample and a positive one raises it.
- R5: A sample whose slot is 4 or more leaves with exactly its input value.
- R6: The sum is clipped to 0 to 255. Results below 0 give 0, and results above 255 give 255.
- R7: out_valid equals in_valid delayed by one clock. out_pix carries the result for the sample presented on the previous clock.
- R8: While in_valid is low, out_pix keeps its last value.
- R9: A cfg_load pulse with in_valid low latches cfg_start and all four offsets together. They take effect for samples presented from the next clock on.
- R10: A cfg_load that coincides with in_valid high is ignored. The earlier configuration stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Strobe that latches a new region configuration |
| cfg_start | input | 5 | First band of the offset window |
| cfg_ofs | input | 16 | Four signed 4-bit offsets, slot 0 in bits [3:0] |
| in_valid | input | 1 | Input sample qualifier |
| in_pix | input | 8 | Input sample |
| out_valid | output | 1 | Output sample qualifier |
| out_pix | output | 8 | Corrected, clipped sample |

## Verification
On every cycle, the in-module properties check four things. The valid flag must follow its input by one clock. Samples outside the window must pass through untouched. A held output must stay stable during idle cycles. An applied offset must move the sample in the direction of its sign. The stored configuration must also stay frozen unless a load is accepted. The exact values the bench scenarios cover are out of reach for these properties: the offset chosen for each slot, the wrap of the window past band 31, saturation at both ends of the range, and a load that collides with a valid sample leaving the old window in force.

// File: rtl/sao_band_apply.sv
module sao_band_apply #(
  parameter int PIX_W  = 8,
  parameter int BAND_W = 5,
  parameter int OFS_W  = 4,
  parameter int WIN    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic [BAND_W-1:0]      cfg_start,
  input  logic [WIN*OFS_W-1:0]   cfg_ofs,
  input  logic                   in_valid,
  input  logic [PIX_W-1:0]       in_pix,
  output logic                   out_valid,
  output logic [PIX_W-1:0]       out_pix
);

  localparam int SHIFT = PIX_W - BAND_W;
  localparam int SUM_W = PIX_W + 2;
  localparam logic [BAND_W-1:0] WIN_L = BAND_W'(WIN);

  logic [BAND_W-1:0]    start_q;
  logic [WIN*OFS_W-1:0] ofs_q;
  logic [BAND_W-1:0]    band, slot;
  logic                 hit;
  logic [OFS_W-1:0]     ofs_sel;
  logic [SUM_W-1:0]     sum;
  logic [PIX_W-1:0]     clipped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      ofs_q   <= '0;
    end else if (cfg_load && !in_valid) begin
      start_q <= cfg_start;
      ofs_q   <= cfg_ofs;
    end
  end

  assign band = in_pix[PIX_W-1:SHIFT];
  assign slot = band - start_q;
  assign hit  = slot < WIN_L;

  always_comb begin
    ofs_sel = '0;
    for (int i = 0; i < WIN; i++)
      if (hit && slot == BAND_W'(i)) ofs_sel = ofs_q[i*OFS_W +: OFS_W];
  end

  assign sum = {2'b00, in_pix} + {{(SUM_W-OFS_W){ofs_sel[OFS_W-1]}}, ofs_sel};

  always_comb begin
    if (sum[SUM_W-1])                 clipped = '0;
    else if (sum[SUM_W-2:PIX_W] != 0) clipped = '1;
    else                              clipped = sum[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_pix <= clipped;
    end
  end

  a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r7_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r5_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hit) |=> out_pix == $past(in_pix));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_pix));
  a_r4_neg_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hit && ofs_sel[OFS_W-1]) |=> out_pix <= $past(in_pix));
  a_r4_pos_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hit && !ofs_sel[OFS_W-1]) |=> out_pix >= $past(in_pix));
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load || in_valid) |=> ($stable(start_q) && $stable(ofs_q)));

endmodule

// File: tb/sao_band_apply_tb.sv
module sao_band_apply_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [4:0]  cfg_start = '0;
  logic [15:0] cfg_ofs = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_pix = '0;
  logic        out_valid;
  logic [7:0]  out_pix;

  int n_chk = 0;
  int n_bad = 0;
  int m_start = 0;
  int m_ofs [4] = '{0, 0, 0, 0};
  int exp_pix = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sao_band_apply u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_start(cfg_start),
    .cfg_ofs(cfg_ofs), .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  function automatic int ref_apply(int p);
    int band = p / 8;
    int slot = (band - m_start + 32) % 32;
    int v = p;
    if (slot < 4) v = p + m_ofs[slot];
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  function automatic int sx4(logic [3:0] x);
    return x[3] ? int'(x) - 16 : int'(x);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int p, bit ld, int st, logic [15:0] of, string tag);
    int ev;
    in_valid = v; in_pix = 8'(p); cfg_load = ld; cfg_start = 5'(st); cfg_ofs = of;
    ev = v;
    if (v) exp_pix = ref_apply(p);
    if (ld && !v) begin
      m_start = st;
      for (int i = 0; i < 4; i++) m_ofs[i] = sx4(of[i*4 +: 4]);
    end
    @(posedge clk); #1;
    check(tag, int'(out_valid), ev);
    check(tag, int'(out_pix), exp_pix);
  endtask

  task automatic load(int st, logic [15:0] of, string tag);
    step(1'b0, 0, 1'b1, st, of, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 valid", int'(out_valid), 0);
    check("R1 pix", int'(out_pix), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1 after", int'(out_pix), 0);
    for (int p = 0; p < 256; p += 5) step(1'b1, p, 1'b0, 0, '0, "R1 zero cfg");

    load(4, {4'hF, 4'h3, 4'h8, 4'h7}, "R9 load");
    for (int p = 0; p < 256; p++) step(1'b1, p, 1'b0, 0, '0, "R2 R4 R5 sweep");

    for (int i = 0; i < 5; i++) step(1'b0, 0, 1'b0, 0, '0, "R8 hold");

    load(30, {4'h2, 4'hE, 4'h5, 4'h9}, "R9 load");
    step(1'b1, 240, 1'b0, 0, '0, "R9 next cycle");
    for (int p = 0; p < 256; p += 3) step(1'b1, p, 1'b0, 0, '0, "R3 wrap");

    load(0, {4'h8, 4'h8, 4'h8, 4'h8}, "R9 load");
    for (int p = 0; p < 40; p++) step(1'b1, p, 1'b0, 0, '0, "R6 low clip");
    load(28, {4'h7, 4'h7, 4'h7, 4'h7}, "R9 load");
    for (int p = 220; p < 256; p++) step(1'b1, p, 1'b0, 0, '0, "R6 high clip");

    step(1'b1, 100, 1'b1, 12, {4'h7, 4'h7, 4'h7, 4'h7}, "R10 collide");
    for (int p = 96; p < 128; p++) step(1'b1, p, 1'b0, 0, '0, "R10 old cfg kept");
    for (int p = 224; p < 256; p += 2) step(1'b1, p, 1'b0, 0, '0, "R10 old cfg kept");

    for (int i = 0; i < 40; i++)
      step(i % 3 != 0, (i * 37) % 256, 1'b0, 0, '0, "R7 R8 mixed");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule